// File: doc/BRIEF.md
# Light Sensor Conversion Sequencer

This block is the digital controller of a light-to-digital converter. A host writes a command register and a control register through a small register-write port. The block then times each integration period and steers a two-way source select. It captures the charge-accumulator count at the end of each period and publishes a conversion result. It also keeps an interrupt status flag that a threshold-event strobe sets.

An integration lasts a fixed power-of-two number of clock cycles chosen by a width code, or, in external timing, it runs from one host sync command to the next. In differential mode the block converts input 1 and then input 2, and reports the signed difference. The accumulator is outside the block. It is seen as a count input, and the block pulses `acc_clr` whenever an integration starts.

Register map on `wr_addr`: 0 = command, 1 = control, 2 = sync command, 3 = interrupt-clear command. The command byte is laid out as: bit 7 enable, bit 6 power-down, bit 5 external timing, bit 4 reserved (reads 0), bits 3:2 source mode, bits 1:0 width code.

Top module: `lsc_seq`

## Requirements
- R1: After reset the command register reads 0x00 at read address 0, the control register reads 0x00 at read address 1, `int_flag` is 0 and no conversion runs. Written command bits read back unchanged, except bit 4, which reads 0.
- R2: Conversions run only while command bit 7 is 1 and bit 6 is 0. Otherwise `result_valid` never pulses.
- R3: With internal timing, width code w (bits 1:0) gives a phase length of 2^(16-4w) cycles and a resolution of n = 16-4w bits. One `acc_clr` pulse marks the start of each phase.
- R4: Mode 00 converts input 1 and mode 01 converts input 2, with `src_sel` held at 0 and 1 respectively. The result is the accumulator count saturated to 2^n-1, zero-extended.
- R5: Mode 10 runs a phase on input 1 (`src_sel`=0) and then one on input 2 (`src_sel`=1). Each count is saturated to 2^(n-1)-1. The result is the first count minus the second, in two's complement sign-extended to 16 bits, so results come every 2·2^(16-4w) cycles.
- R6: Mode 11 performs no conversion.
- R7: With bit 5 set, a write to address 2 with data bit 0 = 1 is a sync. The first sync after a start only begins an integration. Each later sync ends the current phase and starts the next at once. A write to address 2 with data bit 0 = 0 does nothing.
- R8: With internal timing, sync writes do not change the phase timing.
- R9: `result` changes only at the end of a full conversion. `result_valid` pulses for one cycle in the cycle after that end, together with the new value.
- R10: A one-cycle `thresh_evt` sets `int_flag`, which also reads as bit 5 of the control register. Writing the control register with bit 5 = 0 clears the flag, and writing it with bit 5 = 1 leaves the flag unchanged.
- R11: A write to address 3 with data bit 0 = 1 clears `int_flag`. The same write with data bit 0 = 0 leaves it unchanged.
- R12: When `thresh_evt` and a clear fall in the same cycle, `int_flag` ends up set.
- R13: Entering the running state, whether from reset, from enable 0, from power-down or from mode 11, restarts at the first phase. With internal timing the first result follows the write edge by 2^(16-4w)+1 cycles, or by twice the phase length plus one in mode 10.
- R14: A change of bit 5, bits 3:2 or bits 1:0 while running aborts the integration under way and restarts with the new settings, with the same latency as R13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 command, 1 control, 2 sync, 3 clear) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 command, 1 control) |
| rd_data | output | 8 | Read data, combinational |
| thresh_evt | input | 1 | Threshold event strobe, sets the interrupt flag |
| acc_count | input | 16 | Charge accumulator count for the selected source |
| src_sel | output | 1 | Source select: 0 input 1, 1 input 2 |
| acc_clr | output | 1 | Pulse: clear the accumulator, integration starts |
| result | output | 16 | Latest conversion result |
| result_valid | output | 1 | One-cycle pulse when `result` updates |
| int_flag | output | 1 | Interrupt status flag |

## Verification
The bench sweeps the accumulator values through zero, one, the half-scale and full-scale limits and a value past saturation, for every mode at the two shortest widths. A block that clamps a differential phase to n bits instead of n-1 would then report wrong differences at the half-scale points. One with a mis-decoded width code would show a wrong spacing between results. Restart latency is measured after a width change, a mode change and a power-down release. A block that kept counting or kept the second differential phase would deliver its first result early, or would deliver a single-source value. The external-timing test checks that the first sync produces no result and that syncs are ignored under internal timing. The interrupt tests put a set and a clear in the same cycle, where a clear-first priority would drop the flag.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [1:0] {
    SRC_ONE  = 2'b00,
    SRC_TWO  = 2'b01,
    SRC_DIFF = 2'b10,
    SRC_IDLE = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    ADDR_CMD  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_SYNC = 2'd2,
    ADDR_CLR  = 2'd3
  } addr_e;

  typedef struct packed {
    logic      run_en;
    logic      pwr_down;
    logic      ext_time;
    logic      spare;
    src_mode_e src;
    logic [1:0] width;
  } cmd_t;

  localparam int CMD_W   = $bits(cmd_t);
  localparam int INT_BIT = 5;

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              thresh_evt,
  output cmd_t              cmd,
  output logic              sync_req,
  output logic              int_flag,
  output logic [CMD_W-1:0]  rd_data
);

  cmd_t cmd_q, cmd_d;
  logic cmd_en;
  logic int_q, int_d;
  logic clr_req;

  always_comb begin
    cmd_en = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));
    cmd_d = cmd_t'(wr_data);
    cmd_d.spare = 1'b0;
    sync_req = wr_en && (wr_addr == ADDR_W'(ADDR_SYNC)) && wr_data[0];
    clr_req = wr_en && (((wr_addr == ADDR_W'(ADDR_CTRL)) && !wr_data[INT_BIT]) ||
                        ((wr_addr == ADDR_W'(ADDR_CLR)) && wr_data[0]));
    // a new event outranks any clear in the same cycle
    int_d = thresh_evt | (int_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
    end else begin
      int_q <= int_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_CMD)) begin
      rd_data = cmd_q;
    end else if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_data[INT_BIT] = int_q;
    end
  end

  assign cmd      = cmd_q;
  assign int_flag = int_q;

endmodule

// File: rtl/lsc_timer.sv
module lsc_timer
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STEP_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic sync_req,
  output logic phase_end,
  output logic phase,
  output logic acc_clr,
  output logic src_sel
);

  localparam int CFG_W = 5;

  logic [DATA_W-1:0] cnt_q, cnt_d, last_cnt;
  logic              phase_q, phase_d;
  logic              primed_q, primed_d;
  logic              run, run_q;
  logic [CFG_W-1:0]  cfg, cfg_q;
  logic              restart, is_diff;
  int                shamt;

  always_comb begin
    run      = cmd.run_en && !cmd.pwr_down && (cmd.src != SRC_IDLE);
    cfg      = {cmd.ext_time, cmd.src, cmd.width};
    restart  = run && (!run_q || (cfg != cfg_q));
    is_diff  = (cmd.src == SRC_DIFF);
    shamt    = STEP_W * int'(cmd.width);
    last_cnt = {DATA_W{1'b1}} >> shamt;
  end

  always_comb begin
    cnt_d     = cnt_q;
    phase_d   = phase_q;
    primed_d  = primed_q;
    acc_clr   = 1'b0;
    phase_end = 1'b0;
    if (!run) begin
      cnt_d    = '0;
      phase_d  = 1'b0;
      primed_d = 1'b0;
    end else if (restart) begin
      cnt_d    = '0;
      phase_d  = 1'b0;
      primed_d = 1'b0;
      acc_clr  = 1'b1;
    end else if (cmd.ext_time) begin
      if (sync_req) begin
        acc_clr   = 1'b1;
        primed_d  = 1'b1;
        phase_end = primed_q;
      end
    end else if (cnt_q == last_cnt) begin
      cnt_d     = '0;
      acc_clr   = 1'b1;
      phase_end = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (phase_end) begin
      phase_d = is_diff ? ~phase_q : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      primed_q <= 1'b0;
      run_q    <= 1'b0;
      cfg_q    <= '0;
    end else begin
      cnt_q    <= cnt_d;
      phase_q  <= phase_d;
      primed_q <= primed_d;
      run_q    <= run;
      cfg_q    <= cfg;
    end
  end

  always_comb begin
    unique case (cmd.src)
      SRC_TWO:  src_sel = 1'b1;
      SRC_DIFF: src_sel = phase_q;
      default:  src_sel = 1'b0;
    endcase
  end

  assign phase = phase_q;

endmodule

// File: rtl/lsc_result.sv
module lsc_result
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] acc_count,
  input  logic              phase_end,
  input  logic              phase,
  input  src_mode_e         src,
  input  logic [1:0]        width,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);

  logic [DATA_W-1:0] max_full, max_half, sat_full, sat_half;
  logic [DATA_W-1:0] first_q, diff_val, res_q, res_d;
  logic              first_en, res_en, is_diff, valid_q;
  int                shamt;

  always_comb begin
    shamt    = STEP_W * int'(width);
    max_full = {DATA_W{1'b1}} >> shamt;
    max_half = max_full >> 1;
    sat_full = (acc_count > max_full) ? max_full : acc_count;
    sat_half = (acc_count > max_half) ? max_half : acc_count;
    // both operands are below half scale, so the wrap is the sign extension
    diff_val = first_q - sat_half;
    is_diff  = (src == SRC_DIFF);
    first_en = phase_end && is_diff && !phase;
    res_en   = phase_end && (!is_diff || phase);
    res_d    = is_diff ? diff_val : sat_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else if (first_en) begin
      first_q <= sat_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= res_en;
    end
  end

  assign result       = res_q;
  assign result_valid = valid_q;

endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STEP_W = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              thresh_evt,
  input  logic [DATA_W-1:0] acc_count,
  output logic              src_sel,
  output logic              acc_clr,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              int_flag
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  cmd_t       cmd_q;
  logic       sync_req, phase_end, phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  lsc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .thresh_evt (thresh_evt),
    .cmd        (cmd_q),
    .sync_req   (sync_req),
    .int_flag   (int_flag),
    .rd_data    (rd_data)
  );

  lsc_timer #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd       (cmd_q),
    .sync_req  (sync_req),
    .phase_end (phase_end),
    .phase     (phase),
    .acc_clr   (acc_clr),
    .src_sel   (src_sel)
  );

  lsc_result #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_result (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .acc_count    (acc_count),
    .phase_end    (phase_end),
    .phase        (phase),
    .src          (cmd_q.src),
    .width        (cmd_q.width),
    .result       (result),
    .result_valid (result_valid)
  );

endmodule

// File: rtl/lsc_seq_chk.sv
module lsc_seq_chk #(
  parameter int DATA_W = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cmd,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic              thresh_evt,
  input logic              int_flag,
  input logic [DATA_W-1:0] result,
  input logic              result_valid,
  input logic              src_sel,
  input logic              acc_clr
);

  logic              clr_any;
  logic [7:0]        cmd_prev;
  logic [DATA_W-1:0] limit;

  always_comb begin
    clr_any = wr_en && (((wr_addr == 2'd1) && !wr_data[5]) ||
                        ((wr_addr == 2'd3) && wr_data[0]));
    limit = {DATA_W{1'b1}} >> (STEP_W * int'(cmd_prev[1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_prev <= '0;
    end else begin
      cmd_prev <= cmd;
    end
  end

  AST_STOPPED_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd[7] || cmd[6]) |=> !result_valid); // R2
  AST_NOP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[3:2] == 2'b11) |=> !result_valid); // R6
  AST_SRC_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[3:2] == 2'b00) |-> !src_sel); // R4
  AST_SRC_TWO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[3:2] == 2'b01) |-> src_sel); // R4
  AST_UNSIGNED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (cmd_prev[3:2] != 2'b10)) |-> (result <= limit)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result)); // R9
  AST_RESULT_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(acc_clr)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_evt |=> int_flag); // R12
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !thresh_evt) |=> !int_flag); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && !thresh_evt) |=> $stable(int_flag)); // R10

endmodule

bind lsc_seq lsc_seq_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cmd          (cmd_q),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .thresh_evt   (thresh_evt),
  .int_flag     (int_flag),
  .result       (result),
  .result_valid (result_valid),
  .src_sel      (src_sel),
  .acc_clr      (acc_clr)
);

// File: tb/lsc_seq_tb_top.sv
module lsc_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        thresh_evt;
  logic [15:0] acc_count;
  logic        src_sel, acc_clr, result_valid, int_flag;
  logic [15:0] result;
  logic [15:0] a_val, b_val;

  int n_chk = 0;
  int n_fail = 0;
  int nvalid = 0;
  int gap_cnt = 0;
  int last_gap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign acc_count = src_sel ? b_val : a_val;

  lsc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .thresh_evt(thresh_evt), .acc_count(acc_count),
    .src_sel(src_sel), .acc_clr(acc_clr), .result(result), .result_valid(result_valid),
    .int_flag(int_flag)
  );

  always @(negedge clk) begin
    gap_cnt = gap_cnt + 1;
    if (result_valid) begin
      last_gap = gap_cnt;
      gap_cnt = 0;
      nvalid = nvalid + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!result_valid);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic latency(output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!result_valid && lat < 70000);
    #1;
  endtask

  task automatic pulse_evt();
    @(negedge clk); thresh_evt = 1'b1;
    @(negedge clk); thresh_evt = 1'b0;
  endtask

  function automatic int pick(input int idx, input int w);
    int mx;
    mx = (1 << (16 - 4 * w)) - 1;
    case (idx)
      0: return 0;
      1: return 1;
      2: return mx >> 1;
      3: return (mx >> 1) + 1;
      4: return mx;
      default: return mx + 3;
    endcase
  endfunction

  function automatic logic [15:0] expect_res(input int m, input int w, input int a, input int b);
    int mx, hm, sa, sb;
    mx = (1 << (16 - 4 * w)) - 1;
    hm = mx >> 1;
    if (m == 2) begin
      sa = (a > hm) ? hm : a;
      sb = (b > hm) ? hm : b;
      return 16'(sa - sb);
    end
    if (m == 1) return 16'((b > mx) ? mx : b);
    return 16'((a > mx) ? mx : a);
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, n0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    thresh_evt = 1'b0; a_val = '0; b_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd_addr = 2'd0; #1;
    chk(rd_data == 8'h00, "R1 cmd reset", rd_data, 0);
    rd_addr = 2'd1; #1;
    chk(rd_data == 8'h00, "R1 ctrl reset", rd_data, 0);
    chk(int_flag == 1'b0, "R1 flag reset", int_flag, 0);
    idle(40);
    chk(nvalid == 0, "R1 no conversion after reset", nvalid, 0);

    // R2 enable low / power-down high
    a_val = 16'd3;
    wr(2'd0, 8'h03); idle(1); n0 = nvalid; idle(60);
    chk(nvalid == n0, "R2 enable low", nvalid, n0);
    wr(2'd0, 8'hC3); idle(1); n0 = nvalid; idle(60);
    chk(nvalid == n0, "R2 power down", nvalid, n0);
    // R6 no-op mode
    wr(2'd0, 8'h8F); idle(1); n0 = nvalid; idle(60);
    chk(nvalid == n0, "R6 mode 11 idle", nvalid, n0);
    rd_addr = 2'd0; #1;
    chk(rd_data == 8'h8F, "R1 cmd readback", rd_data, 8'h8F);
    wr(2'd0, 8'h9F); rd_addr = 2'd0; #1;
    chk(rd_data == 8'h8F, "R1 reserved bit reads 0", rd_data, 8'h8F);

    // R13 start from idle: first result after N+1
    wr(2'd0, 8'h83); latency(lat);
    chk(lat == 17, "R13 start latency", lat, 17);
    chk(result == 16'd3, "R4 first result", result, 3);

    // R9 result holds between updates
    n0 = result; idle(5);
    chk(result == 16'(n0) && !result_valid, "R9 result hold", result, n0);

    // R3 R4 R5 sweeps
    for (int w = 3; w >= 2; w--) begin
      for (int m = 0; m < 3; m++) begin
        wr(2'd0, 8'(8'h80 | (m << 2) | w));
        wait_valid();
        for (int ia = 0; ia < 6; ia++) begin
          for (int ib = 0; ib < 6; ib++) begin
            a_val = 16'(pick(ia, w));
            b_val = 16'(pick(ib, w));
            wait_valid();
            chk(result == expect_res(m, w, a_val, b_val),
                (m == 2) ? "R5 diff result" : "R4 single result",
                result, expect_res(m, w, a_val, b_val));
          end
        end
        chk(last_gap == ((m == 2) ? 2 : 1) * (1 << (16 - 4 * w)), "R3 result spacing",
            last_gap, ((m == 2) ? 2 : 1) * (1 << (16 - 4 * w)));
        if (m < 2) chk(src_sel == (m == 1), "R4 source select", src_sel, (m == 1));
      end
    end

    // R14 abort on width change, then on mode change
    a_val = 16'd9; b_val = 16'd4;
    wr(2'd0, 8'h82); wait_valid(); idle(30);
    wr(2'd0, 8'h83); latency(lat);
    chk(lat == 17, "R14 width change restart", lat, 17);
    idle(5);
    wr(2'd0, 8'h8B); latency(lat);
    chk(lat == 33, "R14 mode change restart", lat, 33);
    chk(result == 16'd3, "R14 diff after restart", result, 3);

    // R13 power-down release restarts the differential sequence
    a_val = 16'd5; b_val = 16'd2;
    wait_valid(); idle(7);
    wr(2'd0, 8'hCB); idle(1); n0 = nvalid; idle(40);
    chk(nvalid == n0, "R2 power down stops", nvalid, n0);
    wr(2'd0, 8'h8B); latency(lat);
    chk(lat == 33, "R13 power-down release latency", lat, 33);
    chk(result == 16'd3, "R13 first phase restart", result, 3);

    // R7 external timing
    a_val = 16'd9;
    wr(2'd0, 8'hA3); idle(5);
    wr(2'd2, 8'h01);
    chk(result_valid == 1'b0, "R7 first sync only starts", result_valid, 0);
    idle(10);
    wr(2'd2, 8'h00);
    chk(result_valid == 1'b0, "R7 sync with bit0 low", result_valid, 0);
    idle(10);
    wr(2'd2, 8'h01);
    chk(result_valid == 1'b1, "R7 sync ends phase", result_valid, 1);
    chk(result == 16'd9, "R7 ext result", result, 9);
    a_val = 16'd20; idle(3);
    wr(2'd2, 8'h01);
    chk(result_valid == 1'b1 && result == 16'd15, "R7 ext saturated", result, 15);

    // R8 sync ignored under internal timing
    wr(2'd0, 8'h83); wait_valid();
    wr(2'd2, 8'h01); wait_valid();
    chk(last_gap == 16, "R8 sync ignored", last_gap, 16);

    // R10 R11 R12 interrupt flag
    pulse_evt(); #1;
    chk(int_flag == 1'b1, "R10 event sets flag", int_flag, 1);
    rd_addr = 2'd1; #1;
    chk(rd_data == 8'h20, "R10 ctrl bit5 reads flag", rd_data, 8'h20);
    wr(2'd1, 8'h20); #1;
    chk(int_flag == 1'b1, "R10 write 1 no effect", int_flag, 1);
    wr(2'd1, 8'h00); #1;
    chk(int_flag == 1'b0, "R10 write 0 clears", int_flag, 0);
    pulse_evt();
    wr(2'd3, 8'h00); #1;
    chk(int_flag == 1'b1, "R11 clear with bit0 low", int_flag, 1);
    wr(2'd3, 8'h01); #1;
    chk(int_flag == 1'b0, "R11 clear command", int_flag, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01; thresh_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; thresh_evt = 1'b0; #1;
    chk(int_flag == 1'b1, "R12 set beats clear command", int_flag, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00; thresh_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; thresh_evt = 1'b0; #1;
    chk(int_flag == 1'b1, "R12 set beats ctrl clear", int_flag, 1);

    // R3 longer widths
    a_val = 16'd5000;
    wr(2'd0, 8'h81); latency(lat);
    chk(lat == 4097, "R3 width 12 latency", lat, 4097);
    chk(result == 16'd4095, "R3 width 12 saturation", result, 4095);
    a_val = 16'd40000;
    wr(2'd0, 8'h80); latency(lat);
    chk(lat == 65537, "R3 width 16 latency", lat, 65537);
    chk(result == 16'd40000, "R3 width 16 result", result, 40000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule